// File: doc/BRIEF.md
# Loopback expected-value and mask generator

This block sits beside a parallel-port self-test. Each 16-bit word that a test sequencer drives onto the port is also presented here. The block returns two words. One is the value that the external feedback circuit should send back. The other is a care mask that marks which bits of the returned value are meaningful. The sequencer ANDs the returned word with the mask and compares the result with the expected word. That comparison lies outside this block.

The feedback circuit does not simply echo the port. It reroutes and sometimes inverts selected driven bits, and which routing applies depends on two selector bits of the driven word itself. For that reason the generator decodes the selector, forms the expected word for the chosen routing, and zeroes every bit that is don't-care. The result is registered, with one cycle of latency and a valid flag.

Driven bits are named A0 to A15. A0 is the most significant bit (word bit 15) and A15 is word bit 0, so Ak is word bit 15-k.

Top module: `lbk_expect_gen`

## Requirements
- R1: While rst_n is low, out_valid, out_expect and out_mask are all zero.
- R2: out_valid is high in the cycle after a cycle with in_valid high, and low in the cycle after a cycle with in_valid low.
- R3: The routing case is the two-bit code {A6, A7}, which is {in_word[9], in_word[8]}. A0 is in_word[15].
- R4: Case 00: the mask is 16'h7C00. The expected bits 14..12 are 1, bit 11 is ~A8 and bit 10 is ~A9.
- R5: Case 01: the mask is 16'h7CFF. The expected bits 14..12 are 1, bit 11 is ~A0 and bit 10 is ~A1. Bits 7..0 are ~A0..~A7, with ~A0 in bit 7.
- R6: Case 10: the mask is 16'hFC00. Expected bits 15..10 are ~A10..~A15, with ~A10 in bit 15.
- R7: Case 11: the mask is 16'hFCFF. Expected bits 15..10 are A2..A7, with A2 in bit 15. Bits 7..0 are A0..A7, with A0 in bit 7.
- R8: Whenever out_valid is high, out_expect is zero wherever out_mask is zero, and out_mask bits 9 and 8 are zero.
- R9: After a cycle with in_valid low, out_expect and out_mask keep their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | in_word is present this cycle |
| in_word | input | 16 | Word driven onto the port (A0 = bit 15) |
| out_valid | output | 1 | Outputs were computed from the previous cycle's input |
| out_expect | output | 16 | Expected loopback word, zero in don't-care bits |
| out_mask | output | 16 | Care mask for the returned word |

## Verification
A wrong case decode or a misrouted bit in one of the four maps shows up at out_expect or out_mask on the first valid cycle after the offending word. Because the bench sweeps every 16-bit word, each routing path is exercised under both polarities of every source bit. A stale or wrongly loaded output register shows up one cycle after a gap in in_valid: the held words then differ from the values of the last accepted word. A valid flag that lags or leads in_valid is caught on the first cycle where the two disagree.

// File: rtl/lbk_pkg.sv
package lbk_pkg;
    localparam int WORD_W    = 16;
    localparam int BYTE_W    = 8;
    localparam int NUM_CASES = 4;
    localparam int SEL_HI    = WORD_W - 1 - 6;   // A6
    localparam int SEL_LO    = WORD_W - 1 - 7;   // A7

    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        logic  valid;
        word_t expect_w;
        word_t mask_w;
    } out_st_t;

    localparam word_t MASK_C0 = 16'h7C00;
    localparam word_t MASK_C1 = 16'h7CFF;
    localparam word_t MASK_C2 = 16'hFC00;
    localparam word_t MASK_C3 = 16'hFCFF;

    // Driven bit Ak, with A0 the most significant bit
    function automatic logic bit_a(input word_t w, input int k);
        return w[WORD_W-1-k];
    endfunction
endpackage

// File: rtl/lbk_case_sel.sv
module lbk_case_sel
    import lbk_pkg::*;
#(
    parameter int N = NUM_CASES
) (
    input  word_t          in_word,
    output logic [N-1:0]   case_oh
);
    logic [1:0] code_d;

    always_comb begin
        code_d = {in_word[SEL_HI], in_word[SEL_LO]};
    end

    for (genvar c = 0; c < N; c++) begin : g_dec
        assign case_oh[c] = (code_d == c[1:0]);
    end
endmodule

// File: rtl/lbk_case_map.sv
module lbk_case_map
    import lbk_pkg::*;
#(
    parameter int CASE_ID = 0
) (
    input  word_t in_word,
    output word_t map_expect,
    output word_t map_mask
);
    word_t raw_d;
    word_t mask_d;

    if (CASE_ID == 0) begin : g_c0
        always_comb begin
            raw_d      = '0;
            raw_d[14]  = 1'b1;
            raw_d[13]  = 1'b1;
            raw_d[12]  = 1'b1;
            raw_d[11]  = ~bit_a(in_word, 8);
            raw_d[10]  = ~bit_a(in_word, 9);
            mask_d     = MASK_C0;
        end
    end else if (CASE_ID == 1) begin : g_c1
        always_comb begin
            raw_d      = '0;
            raw_d[14]  = 1'b1;
            raw_d[13]  = 1'b1;
            raw_d[12]  = 1'b1;
            raw_d[11]  = ~bit_a(in_word, 0);
            raw_d[10]  = ~bit_a(in_word, 1);
            for (int j = 0; j < BYTE_W; j++) begin
                raw_d[BYTE_W-1-j] = ~bit_a(in_word, j);
            end
            mask_d     = MASK_C1;
        end
    end else if (CASE_ID == 2) begin : g_c2
        always_comb begin
            raw_d = '0;
            for (int j = 0; j < 6; j++) begin
                raw_d[WORD_W-1-j] = ~bit_a(in_word, 10 + j);
            end
            mask_d = MASK_C2;
        end
    end else begin : g_c3
        always_comb begin
            raw_d = '0;
            for (int j = 0; j < 6; j++) begin
                raw_d[WORD_W-1-j] = bit_a(in_word, 2 + j);
            end
            for (int j = 0; j < BYTE_W; j++) begin
                raw_d[BYTE_W-1-j] = bit_a(in_word, j);
            end
            mask_d = MASK_C3;
        end
    end

    assign map_expect = raw_d & mask_d;
    assign map_mask   = mask_d;
endmodule

// File: rtl/lbk_onehot_mux.sv
module lbk_onehot_mux
    import lbk_pkg::*;
#(
    parameter int N = NUM_CASES
) (
    input  logic [N-1:0]        sel_oh,
    input  word_t [N-1:0]       exp_in,
    input  word_t [N-1:0]       mask_in,
    output word_t               exp_out,
    output word_t               mask_out
);
    always_comb begin
        exp_out  = '0;
        mask_out = '0;
        for (int c = 0; c < N; c++) begin
            exp_out  = exp_out  | (exp_in[c]  & {WORD_W{sel_oh[c]}});
            mask_out = mask_out | (mask_in[c] & {WORD_W{sel_oh[c]}});
        end
    end
endmodule

// File: rtl/lbk_expect_gen.sv
module lbk_expect_gen
    import lbk_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [15:0] in_word,
    output logic        out_valid,
    output logic [15:0] out_expect,
    output logic [15:0] out_mask
);
    logic [NUM_CASES-1:0] case_oh;
    word_t [NUM_CASES-1:0] exp_arr;
    word_t [NUM_CASES-1:0] mask_arr;
    word_t sel_exp;
    word_t sel_mask;
    out_st_t st_d;
    out_st_t st_q;

    lbk_case_sel #(.N(NUM_CASES)) i_sel (
        .in_word (in_word),
        .case_oh (case_oh)
    );

    for (genvar c = 0; c < NUM_CASES; c++) begin : g_map
        lbk_case_map #(.CASE_ID(c)) i_map (
            .in_word    (in_word),
            .map_expect (exp_arr[c]),
            .map_mask   (mask_arr[c])
        );
    end

    lbk_onehot_mux #(.N(NUM_CASES)) i_mux (
        .sel_oh   (case_oh),
        .exp_in   (exp_arr),
        .mask_in  (mask_arr),
        .exp_out  (sel_exp),
        .mask_out (sel_mask)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) begin
            st_d.expect_w = sel_exp;
            st_d.mask_w   = sel_mask;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid  = st_q.valid;
    assign out_expect = st_q.expect_w;
    assign out_mask   = st_q.mask_w;

    // R3
    case_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(case_oh));

    // R2
    valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R2
    valid_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R8
    dont_care_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (((out_expect & ~out_mask) == 16'h0) && (out_mask[9:8] == 2'b00)));

    // R7
    case11_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_word[9:8] == 2'b11) |=> (out_mask == 16'hFCFF));

    // R4
    case00_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_word[9:8] == 2'b00) |=> (out_mask == 16'h7C00));

    // R9
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_expect) && $stable(out_mask)));
endmodule

// File: tb/test_lbk_expect_gen.sv
module test_lbk_expect_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] in_word = 16'h0;
    logic        out_valid;
    logic [15:0] out_expect;
    logic [15:0] out_mask;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // reference state
    logic        m_valid = 1'b0;
    logic [15:0] m_exp = 16'h0;
    logic [15:0] m_mask = 16'h0;
    int          m_case = 0;

    always #2.5 clk = ~clk;

    lbk_expect_gen i_lbk_expect_gen (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_word    (in_word),
        .out_valid  (out_valid),
        .out_expect (out_expect),
        .out_mask   (out_mask)
    );

    function automatic logic [15:0] ref_mask(input logic [15:0] w);
        int code;
        code = int'(w[9:8]);   // R3: {A6, A7}
        case (code)
            0: return 16'h7C00;
            1: return 16'h7CFF;
            2: return 16'hFC00;
            default: return 16'hFCFF;
        endcase
    endfunction

    function automatic logic [15:0] ref_exp(input logic [15:0] w);
        logic [15:0] nw;
        int e;
        nw = ~w;
        case (int'(w[9:8]))
            0: e = 'h7000 | ((int'(nw) >> 7) & 1) << 11 | ((int'(nw) >> 6) & 1) << 10;
            1: e = 'h7000 | ((int'(nw) >> 14) & 3) << 10 | ((int'(nw) >> 8) & 'hFF);
            2: e = (int'(nw) & 'h3F) << 10;
            default: e = ((int'(w) >> 8) & 'h3F) << 10 | ((int'(w) >> 8) & 'hFF);
        endcase
        return e[15:0];
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_valid <= 1'b0;
            m_exp   <= 16'h0;
            m_mask  <= 16'h0;
        end else begin
            m_valid <= in_valid;
            if (in_valid) begin
                m_exp  <= ref_exp(in_word);
                m_mask <= ref_mask(in_word);
                m_case <= int'(in_word[9:8]);
            end
        end
    end

    task automatic check_word(input string req, input logic [15:0] act, input logic [15:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic compare_all(input logic holding);
        string req;
        checks++;
        if (out_valid !== m_valid) begin
            errors++;
            $display("FAIL R2 out_valid actual=%b expected=%b", out_valid, m_valid);
        end
        if (holding) req = "R9";
        else begin
            case (m_case)
                0: req = "R3/R4";
                1: req = "R3/R5";
                2: req = "R3/R6";
                default: req = "R3/R7";
            endcase
        end
        check_word(req, out_expect, m_exp, "out_expect");
        check_word(req, out_mask, m_mask, "out_mask");
        if (out_valid) begin
            check_word("R8", out_expect & ~out_mask, 16'h0, "dont-care bits");
            check_word("R8", out_mask & 16'h0300, 16'h0, "mask bits 9..8");
        end
    endtask

    initial begin
        logic was_idle;
        was_idle = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check_word("R1", {15'h0, out_valid}, 16'h0, "out_valid");
        check_word("R1", out_expect, 16'h0, "out_expect");
        check_word("R1", out_mask, 16'h0, "out_mask");
        rst_n = 1'b1;
        for (int w = 0; w < 65536; w++) begin
            @(negedge clk);
            compare_all(was_idle);
            in_word  = w[15:0];
            in_valid = (w % 7) != 3;
            was_idle = !in_valid;
        end
        @(negedge clk);
        compare_all(was_idle);
        // corner words, one per case, with all-ones and all-zeros neighbours
        foreach (in_word[i]) begin end
        for (int k = 0; k < 8; k++) begin
            in_word  = (k % 2 == 0) ? {6'h00, k[2:1], 8'h00} : {6'h3F, k[2:1], 8'hFF};
            in_valid = 1'b1;
            @(negedge clk);
            compare_all(1'b0);
        end
        in_valid = 1'b0;
        in_word  = 16'hFFFF;
        @(negedge clk);
        compare_all(1'b1);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule